// File: doc/BRIEF.md
# CORDIC direction vector generator

This block converts an integer rotation angle into the complete control word for a pipelined CORDIC rotator that has no 45° stage. The angle arrives as an unsigned integer in [0, N−1], where N = 2^ANG_W and one unit equals 2π/N. The block produces two coarse flags, a half-turn and a quarter-turn. Together they bring the rotation into a window of ±45°. It also produces M micro-rotation directions δ1..δM, each ±1, for the angles atan(2^-i). Because no direction is ever zero, the rotator that consumes the word has a fixed gain.

The first K−1 directions are found the classical way. The sign of the running remainder picks the direction, and the exact micro-angle, held as a fixed-point constant, is then added or subtracted. For indices K..M the micro-angles are close to a binary series, α_i ≈ 2·α_(i+1). The remainder is therefore scaled by 1/α_M, offset and rounded, and the bits of that integer are read out directly as directions.

The block accepts a new angle on every clock and returns its control word a fixed number of cycles later. The number of micro-rotations M, the exact/approximate split point K and the internal angle width CALC_W are all parameters. Each one trades precision against area.

Top module: `cordic_dir_gen`

## Requirements
- R1: The octant is o = angle_i[ANG_W-1:ANG_W-3]. half_o is 1 exactly when o is 3, 4, 5 or 6. quarter_o is 1 exactly when o is 1, 2, 5 or 6. The coarse remainder this leaves lies in [−45°, +45°).
- R2: dir_o bit i−1 carries δ_i, where 1 means +atan(2^-i) (angle increasing) and 0 means −atan(2^-i). δ1 is +1 exactly when the coarse remainder is ≥ 0, which is when the octant o is even.
- R3: Each word is checked against the angle θ·2π/N, taken modulo 2π. The word's reconstructed angle is π·half_o + (π/2)·quarter_o + Σ ±atan(2^-i). It must lie within 3·atan(2^-M) of that angle, for every θ in [0, N−1].
- R4: The control word for an angle presented before clock edge t appears on the outputs after edge t+K. That gives a latency of K+1 clocks. A new angle is accepted on every clock.
- R5: With rst high at a rising edge, the outputs after that edge are half_o = 0, quarter_o = 0 and dir_o = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| angle_i | input | ANG_W | Rotation angle in units of 2π/N |
| half_o | output | 1 | Apply the 180° rotation |
| quarter_o | output | 1 | Apply the 90° rotation |
| dir_o | output | M | Micro-rotation directions, bit i−1 for δ_i, 1 = positive |

## Verification
The bench aims at the octant boundaries: θ = N/8, 3N/8, 5N/8 and 7N/8, together with the values just below them. There, a quadrant rounding that is off by one would leave a 90° error, and a wrong sign would flip δ1. θ = 0 and the other exact multiples of N/4 leave a remainder of exactly zero. A sign test that treated zero as negative would flip δ1, and that shows up in the R2 check. An offset or rounding slip in the binary read-out of the fine directions would push the reconstructed angle out by several α_M. A full sweep of every angle, followed by random angles, exposes that as an R3 failure anywhere in the circle. A single-angle pulse and the per-sample history matching catch a pipeline that is one stage too long or too short.

// File: rtl/cdg_pkg.sv
package cdg_pkg;

  localparam real TWO_PI = 6.283185307179586;

  // Micro-angle atan(2^-idx) in units of one turn / 2^w, rounded.
  function automatic longint micro_angle(input int idx, input int w);
    real a;
    a = $atan(2.0 ** (-idx)) / TWO_PI * (2.0 ** w);
    return longint'(a);
  endfunction

  // Fixed-point reciprocal of twice the smallest micro-angle, scaled by 2^sh.
  function automatic longint fine_recip(input int m, input int w, input int sh);
    real a;
    a = $atan(2.0 ** (-m)) / TWO_PI * (2.0 ** w);
    return longint'((2.0 ** sh) / (2.0 * a));
  endfunction

endpackage

// File: rtl/cdg_octant.sv
module cdg_octant #(
  parameter int ANG_W  = 10,
  parameter int CALC_W = 20
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [ANG_W-1:0]         angle_i,
  output logic                     half_o,
  output logic                     quarter_o,
  output logic signed [CALC_W-1:0] rem_o
);
  localparam int SHIFT = CALC_W - ANG_W;
  localparam logic signed [CALC_W-1:0] EIGHTH = CALC_W'(longint'(1) << (CALC_W - 3));

  logic [2:0]       oct;
  logic [1:0]       quad;
  logic [ANG_W-1:0] diff;
  logic signed [CALC_W-1:0] rem_nx;

  // Round the octant index to the nearest quadrant: octants 7 and 0 map to 0.
  always_comb begin
    oct    = angle_i[ANG_W-1 -: 3];
    quad   = oct[2:1] + {1'b0, oct[0]};
    diff   = angle_i - {quad, {(ANG_W-2){1'b0}}};
    rem_nx = {diff, {SHIFT{1'b0}}};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      half_o    <= 1'b0;
      quarter_o <= 1'b0;
      rem_o     <= '0;
    end else begin
      half_o    <= quad[1];
      quarter_o <= quad[0];
      rem_o     <= rem_nx;
    end
  end

  logic oct_half, oct_quarter;
  always_comb begin
    oct_half    = oct inside {3'd3, 3'd4, 3'd5, 3'd6};
    oct_quarter = oct inside {3'd1, 3'd2, 3'd5, 3'd6};
  end

  // R1
  coarse_flag_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (half_o == $past(oct_half)) && (quarter_o == $past(oct_quarter)));

  // R1
  coarse_range_chk: assert property (@(posedge clk) disable iff (rst)
    (rem_o >= -EIGHTH) && (rem_o < EIGHTH));

endmodule

// File: rtl/cdg_exact_step.sv
module cdg_exact_step #(
  parameter int     CALC_W = 20,
  parameter int     M      = 12,
  parameter int     IDX    = 1,
  parameter longint ALPHA  = 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     half_i,
  input  logic                     quarter_i,
  input  logic [M-1:0]             dir_i,
  input  logic signed [CALC_W-1:0] rem_i,
  output logic                     half_o,
  output logic                     quarter_o,
  output logic [M-1:0]             dir_o,
  output logic signed [CALC_W-1:0] rem_o
);
  localparam logic signed [CALC_W-1:0] ALPHA_V = CALC_W'(ALPHA);
  localparam logic [CALC_W:0]          TWO_A   = (CALC_W+1)'(2 * ALPHA);

  logic [M-1:0]             dir_nx;
  logic signed [CALC_W-1:0] rem_nx;

  // Non-negative remainder rotates forward (+1), negative rotates back (-1).
  always_comb begin
    dir_nx        = dir_i;
    dir_nx[IDX-1] = ~rem_i[CALC_W-1];
    if (rem_i[CALC_W-1]) rem_nx = rem_i + ALPHA_V;
    else                 rem_nx = rem_i - ALPHA_V;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      half_o    <= 1'b0;
      quarter_o <= 1'b0;
      dir_o     <= '0;
      rem_o     <= '0;
    end else begin
      half_o    <= half_i;
      quarter_o <= quarter_i;
      dir_o     <= dir_nx;
      rem_o     <= rem_nx;
    end
  end

  logic [CALC_W-1:0] mag_in, mag_out;
  always_comb begin
    mag_in  = rem_i[CALC_W-1] ? CALC_W'(-rem_i) : rem_i;
    mag_out = rem_o[CALC_W-1] ? CALC_W'(-rem_o) : rem_o;
  end

  // R3: a remainder within two micro-angles leaves at most one behind
  exact_shrink_chk: assert property (@(posedge clk) disable iff (rst)
    ({1'b0, mag_in} <= TWO_A) |=> (mag_out <= CALC_W'(ALPHA)));

endmodule

// File: rtl/cdg_fine_map.sv
module cdg_fine_map #(
  parameter int CALC_W = 20,
  parameter int M      = 12,
  parameter int K      = 5
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     half_i,
  input  logic                     quarter_i,
  input  logic [M-1:0]             dir_i,
  input  logic signed [CALC_W-1:0] rem_i,
  output logic                     half_o,
  output logic                     quarter_o,
  output logic [M-1:0]             dir_o
);
  localparam int     J       = M - K + 1;
  localparam int     SH      = CALC_W + 4;
  localparam int     RCP_W   = M + 8;
  localparam int     PW      = CALC_W + RCP_W + 1;
  localparam longint RECIP   = cdg_pkg::fine_recip(M, CALC_W, SH);
  localparam logic signed [PW-1:0] RCP_S = PW'(RECIP);
  localparam logic signed [PW-1:0] OFFS  = PW'(longint'(1) << (J - 1));
  localparam logic signed [PW-1:0] MAXB  = PW'((longint'(1) << J) - 1);

  logic signed [PW-1:0] rem_ext, prod, bsum;
  logic [J-1:0]         bits;
  logic [M-1:0]         dir_nx;

  // bits = floor(rem / (2*alpha_M) + 2^(J-1)), clamped to the J-bit range;
  // bit (M-i) of it selects delta_i for i = K..M.
  always_comb begin
    rem_ext = PW'(rem_i);
    prod    = rem_ext * RCP_S;
    bsum    = (prod >>> SH) + OFFS;
    if (bsum < 0)          bits = '0;
    else if (bsum > MAXB)  bits = '1;
    else                   bits = bsum[J-1:0];
    dir_nx = dir_i;
    for (int i = K; i <= M; i++) dir_nx[i-1] = bits[M-i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      half_o    <= 1'b0;
      quarter_o <= 1'b0;
      dir_o     <= '0;
    end else begin
      half_o    <= half_i;
      quarter_o <= quarter_i;
      dir_o     <= dir_nx;
    end
  end

  // R5
  out_reset_chk: assert property (@(posedge clk)
    (!rst && $past(rst)) |-> (dir_o == '0) && !half_o && !quarter_o);

  // R2: the leading exact direction is never overwritten by the fine map
  fine_keep_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> dir_o[0] == $past(dir_i[0]));

endmodule

// File: rtl/cordic_dir_gen.sv
module cordic_dir_gen #(
  parameter int ANG_W  = 10,
  parameter int M      = 12,
  parameter int K      = 5,
  parameter int CALC_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ANG_W-1:0] angle_i,
  output logic             half_o,
  output logic             quarter_o,
  output logic [M-1:0]     dir_o
);
  localparam int STAGES = K - 1;

  logic signed [CALC_W-1:0] rem_s     [0:STAGES];
  logic [M-1:0]             dir_s     [0:STAGES];
  logic                     half_s    [0:STAGES];
  logic                     quarter_s [0:STAGES];

  assign dir_s[0] = '0;

  cdg_octant #(
    .ANG_W  (ANG_W),
    .CALC_W (CALC_W)
  ) u_octant (
    .clk       (clk),
    .rst       (rst),
    .angle_i   (angle_i),
    .half_o    (half_s[0]),
    .quarter_o (quarter_s[0]),
    .rem_o     (rem_s[0])
  );

  for (genvar g = 1; g <= STAGES; g++) begin : g_exact
    cdg_exact_step #(
      .CALC_W (CALC_W),
      .M      (M),
      .IDX    (g),
      .ALPHA  (cdg_pkg::micro_angle(g, CALC_W))
    ) u_step (
      .clk       (clk),
      .rst       (rst),
      .half_i    (half_s[g-1]),
      .quarter_i (quarter_s[g-1]),
      .dir_i     (dir_s[g-1]),
      .rem_i     (rem_s[g-1]),
      .half_o    (half_s[g]),
      .quarter_o (quarter_s[g]),
      .dir_o     (dir_s[g]),
      .rem_o     (rem_s[g])
    );
  end

  cdg_fine_map #(
    .CALC_W (CALC_W),
    .M      (M),
    .K      (K)
  ) u_fine (
    .clk       (clk),
    .rst       (rst),
    .half_i    (half_s[STAGES]),
    .quarter_i (quarter_s[STAGES]),
    .dir_i     (dir_s[STAGES]),
    .rem_i     (rem_s[STAGES]),
    .half_o    (half_o),
    .quarter_o (quarter_o),
    .dir_o     (dir_o)
  );

endmodule

// File: tb/test_cordic_dir_gen.sv
module test_cordic_dir_gen;
  localparam int  AW  = 10;
  localparam int  MM  = 12;
  localparam int  KK  = 5;
  localparam int  CW  = 20;
  localparam int  N   = 1 << AW;
  localparam int  LAT = KK + 1;
  localparam real PI  = 3.14159265358979323846;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] angle = '0;
  logic          half, quarter;
  logic [MM-1:0] dir;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;
  int hq[$];

  always #5 clk = ~clk;

  cordic_dir_gen #(.ANG_W(AW), .M(MM), .K(KK), .CALC_W(CW)) i_cordic_dir_gen (
    .clk(clk), .rst(rst), .angle_i(angle),
    .half_o(half), .quarter_o(quarter), .dir_o(dir)
  );

  function automatic int oct_of(input int th);
    return (th >> (AW - 3)) & 7;
  endfunction

  function automatic bit exp_half(input int th);
    int o;
    o = oct_of(th);
    return (o >= 3) && (o <= 6);
  endfunction

  function automatic bit exp_quarter(input int th);
    int o;
    o = oct_of(th);
    return (o == 1) || (o == 2) || (o == 5) || (o == 6);
  endfunction

  function automatic real recon_err(input int th, input bit h, input bit q,
                                    input logic [MM-1:0] d);
    real a, t, e;
    a = 0.0;
    if (h) a = a + PI;
    if (q) a = a + PI / 2.0;
    for (int i = 1; i <= MM; i++) begin
      if (d[i-1]) a = a + $atan(2.0 ** (-i));
      else        a = a - $atan(2.0 ** (-i));
    end
    t = 2.0 * PI * real'(th) / real'(N);
    e = a - t;
    while (e > PI)   e = e - 2.0 * PI;
    while (e <= -PI) e = e + 2.0 * PI;
    return e;
  endfunction

  task automatic check_bit(input string req, input bit act, input bit expv, input int th);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s theta=%0d actual=%0b expected=%0b", req, th, act, expv);
    end
  endtask

  task automatic check_sample(input int th);
    real e, tol;
    check_bit("R1 half", half, exp_half(th), th);
    check_bit("R1 quarter", quarter, exp_quarter(th), th);
    check_bit("R2 delta1", dir[0], (oct_of(th) % 2) == 0, th);
    tol = 3.0 * $atan(2.0 ** (-MM));
    e = recon_err(th, half, quarter, dir);
    total++;
    if ((e > tol) || (e < -tol)) begin
      bad++;
      $display("FAIL R3 theta=%0d actual_err=%g expected_within=%g dir=%b", th, e, tol, dir);
    end
  endtask

  // Output seen at a falling edge belongs to the angle driven LAT falling edges earlier (R4).
  task automatic step(input int th);
    @(negedge clk);
    if (hq.size() == LAT) check_sample(hq.pop_front());
    angle = th[AW-1:0];
    hq.push_back(th);
  endtask

  task automatic check_zero(input string req);
    total++;
    if (half !== 1'b0 || quarter !== 1'b0 || dir !== '0) begin
      bad++;
      $display("FAIL %s actual=%0b/%0b/%b expected=0/0/0", req, half, quarter, dir);
    end
  endtask

  initial begin
    int dlist[12];
    void'($urandom(32'd61803));
    dlist = '{0, 1, N/8 - 1, N/8, N/4, 3*N/8, N/2, 5*N/8, 3*N/4, 7*N/8 - 1, 7*N/8, N - 1};

    repeat (3) @(negedge clk);
    check_zero("R5 in reset");
    rst = 1'b0;

    // R4: single pulse of a half-turn angle
    @(negedge clk); angle = AW'(N/2);
    @(negedge clk); angle = '0;
    repeat (LAT - 2) @(negedge clk);
    check_bit("R4 early", half, 1'b0, N/2);
    @(negedge clk);
    check_bit("R4 on time", half, 1'b1, N/2);
    @(negedge clk);
    check_bit("R4 after", half, 1'b0, N/2);

    foreach (dlist[i]) step(dlist[i]);
    for (int t = 0; t < N; t++) step(t);
    for (int r = 0; r < 2000; r++) step(int'($urandom % N));
    repeat (LAT) step(0);

    // R5: reset in the middle of traffic clears the word
    @(negedge clk); angle = AW'(3*N/4);
    repeat (LAT) @(negedge clk);
    check_bit("R1 steady", half & quarter, 1'b1, 3*N/4);
    rst = 1'b1;
    @(negedge clk);
    check_zero("R5 mid-run");
    rst = 1'b0;

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R4 watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule